// File: doc/BRIEF.md
# DRAM Port Burst Writer

This block sits between a local streaming FIFO and the user port of a DRAM controller. It pops 128-bit words from the local FIFO and places each one in the controller's write-data FIFO. When a full burst of 64 words is staged there, it issues one write-with-auto-precharge command that carries the burst length and a byte address. It then moves the address on by one burst (1 KB) for the next transfer. The local FIFO, the write-data FIFO and the command FIFO all run on the same user clock as the block.

A three-state machine sequences the work. `CAL_WAIT` holds everything idle until the calibration-done input is high, then moves to `FILL`. `FILL` pops and stages words. It moves to `ISSUE` on the edge that stores the 64th word. `ISSUE` presents the command once the internal request flag is set and the command FIFO is not full, and returns to `FILL` in that same cycle. The request flag is armed one word early, when 63 words are stored. It is cleared by seeing the command strobe together with the write-with-auto-precharge opcode. As a result, the command can go out in the cycle right after the last word is stored.

Top module: `dram_burst_feeder`

## Requirements
- R1: While calibration-done has not yet been seen high, `src_rd_en`, `wfifo_en` and `cmd_en` all stay low, even when the local FIFO holds data.
- R2: `src_rd_en` is high in exactly the cycles where calibration has been seen, `src_empty` is low, `wfifo_full` is low and fewer than 64 words have been popped in the current burst. Each burst pops exactly 64 words.
- R3: A popped word appears on `wfifo_data` with `wfifo_en` high in the cycle after the pop. If `wfifo_full` is high in that cycle, the word is held and written in the first later cycle where `wfifo_full` is low. `wfifo_en` is never high while `wfifo_full` is high. Words are written in pop order.
- R4: `cmd_en` is high only after 64 words of the current burst have been written into the write-data FIFO.
- R5: `cmd_en` is high for exactly one cycle per burst, and only in a cycle where `cmd_full` is low. While `cmd_full` stays high the command is held back.
- R6: Whenever `cmd_en` is high, `cmd_op` is 3'b010 (write with auto precharge; the opcode set is 000 write, 001 read, 010 write with auto precharge, 011 read with auto precharge, 100 refresh). `cmd_len` is 63, meaning length minus one, so 64 words. `wfifo_mask` is always all zeros, since a high mask bit would drop its byte.
- R7: The first command carries byte address 0. Each issued command advances `cmd_addr` by 1024, modulo 2^ADDR_W.
- R8: With `cmd_full` low, `cmd_en` is high in the cycle immediately after the cycle in which the 64th word is written.
- R9: While reset is asserted, `src_rd_en`, `wfifo_en` and `cmd_en` are low and `cmd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock shared with all three FIFOs |
| rst_n | input | 1 | Active-low synchronous reset |
| calib_ok | input | 1 | Controller calibration finished |
| src_empty | input | 1 | Local FIFO has no word |
| src_rd_en | output | 1 | Pop request to the local FIFO |
| src_data | input | DATA_W | Local FIFO read data, valid the cycle after a pop |
| wfifo_en | output | 1 | Write strobe into the controller write-data FIFO |
| wfifo_data | output | DATA_W | Word written into the write-data FIFO |
| wfifo_mask | output | DATA_W/8 | Byte mask, high masks a byte (always zero) |
| wfifo_full | input | 1 | Write-data FIFO full |
| cmd_en | output | 1 | Command FIFO push strobe |
| cmd_op | output | 3 | Command opcode |
| cmd_len | output | BL_W | Burst length minus one |
| cmd_addr | output | ADDR_W | Byte address of the burst |
| cmd_full | input | 1 | Command FIFO full |

## Verification
The pop request and the command strobe are combinational on the current full and empty flags, so they are judged in the same cycle the flags are driven. A popped word is due on the write-data port one cycle later, or later still if the write-data FIFO reports full. The bench samples on the falling edge and keeps running counts of pops, writes and pending words, which yields the exact expected value of every strobe in every cycle. The command is expected in the cycle right after the 64th write whenever the command FIFO is not full, and the first burst checks this gap explicitly.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [2:0] {
        OP_WR      = 3'b000,
        OP_RD      = 3'b001,
        OP_WR_AP   = 3'b010,
        OP_RD_AP   = 3'b011,
        OP_REFRESH = 3'b100
    } dram_op_e;

    typedef enum logic [1:0] {
        ST_CAL_WAIT = 2'd0,
        ST_FILL     = 2'd1,
        ST_ISSUE    = 2'd2
    } bw_state_e;

endpackage

// File: rtl/bw_stage.sv
module bw_stage #(
    parameter int DATA_W = 128,
    parameter int BURST  = 64,
    localparam int CNT_W = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              burst_clr,
    input  logic              src_empty,
    input  logic [DATA_W-1:0] src_data,
    input  logic              wfifo_full,
    output logic              src_rd_en,
    output logic              wfifo_en,
    output logic [DATA_W-1:0] wfifo_data,
    output logic              arm_req,
    output logic              put_last
);
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(BURST);
    localparam logic [CNT_W-1:0] ARM_AT  = CNT_W'(BURST - 1);

    logic [CNT_W-1:0] pop_cnt;
    logic [CNT_W-1:0] put_cnt;
    logic             stage_vld;

    // a staged word is only written while the write FIFO has room
    assign wfifo_en   = stage_vld & ~wfifo_full;
    assign wfifo_data = src_data;
    assign src_rd_en  = fill_en & ~src_empty & ~wfifo_full & (pop_cnt < LIMIT);
    assign arm_req    = (put_cnt == ARM_AT);
    assign put_last   = wfifo_en & (put_cnt == ARM_AT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_vld <= 1'b0;
            pop_cnt   <= '0;
            put_cnt   <= '0;
        end else begin
            stage_vld <= src_rd_en | (stage_vld & ~wfifo_en);
            if (burst_clr) begin
                pop_cnt <= '0;
                put_cnt <= '0;
            end else begin
                pop_cnt <= pop_cnt + CNT_W'(src_rd_en);
                put_cnt <= put_cnt + CNT_W'(wfifo_en);
            end
        end
    end

endmodule

// File: rtl/bw_req_flag.sv
module bw_req_flag
    import bw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       cmd_en,
    input  logic [2:0] cmd_op,
    output logic       req
);
    logic seen_issue;

    assign seen_issue = cmd_en & (cmd_op == OP_WR_AP);

    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if (seen_issue)
            req <= 1'b0;
        else if (arm)
            req <= 1'b1;
    end

endmodule

// File: rtl/bw_addr_step.sv
module bw_addr_step #(
    parameter int ADDR_W = 30,
    parameter int STEP   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (adv)
            addr <= addr + INC;
    end

endmodule

// File: rtl/dram_burst_feeder.sv
module dram_burst_feeder
    import bw_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int BURST  = 64,
    parameter int BL_W   = 6,
    parameter int ADDR_W = 30,
    localparam int MASK_W = DATA_W / 8,
    localparam int STEP   = BURST * MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calib_ok,
    input  logic              src_empty,
    output logic              src_rd_en,
    input  logic [DATA_W-1:0] src_data,
    output logic              wfifo_en,
    output logic [DATA_W-1:0] wfifo_data,
    output logic [MASK_W-1:0] wfifo_mask,
    input  logic              wfifo_full,
    output logic              cmd_en,
    output logic [2:0]        cmd_op,
    output logic [BL_W-1:0]   cmd_len,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_full
);
    localparam logic [BL_W-1:0] LEN_CODE = BL_W'(BURST - 1);

    bw_state_e state, state_nx;
    logic      fill_en;
    logic      arm_req;
    logic      put_last;
    logic      req;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_CAL_WAIT;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CAL_WAIT: if (calib_ok) state_nx = ST_FILL;
            ST_FILL:     if (put_last) state_nx = ST_ISSUE;
            ST_ISSUE:    if (cmd_en)   state_nx = ST_FILL;
            default:     state_nx = ST_CAL_WAIT;
        endcase
    end

    always_comb begin
        fill_en    = (state == ST_FILL);
        cmd_en     = (state == ST_ISSUE) & req & ~cmd_full;
        cmd_op     = OP_WR_AP;
        cmd_len    = LEN_CODE;
        wfifo_mask = '0;
    end

    bw_stage #(
        .DATA_W(DATA_W),
        .BURST (BURST)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .burst_clr (cmd_en),
        .src_empty (src_empty),
        .src_data  (src_data),
        .wfifo_full(wfifo_full),
        .src_rd_en (src_rd_en),
        .wfifo_en  (wfifo_en),
        .wfifo_data(wfifo_data),
        .arm_req   (arm_req),
        .put_last  (put_last)
    );

    bw_req_flag u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm_req),
        .cmd_en(cmd_en),
        .cmd_op(cmd_op),
        .req   (req)
    );

    bw_addr_step #(
        .ADDR_W(ADDR_W),
        .STEP  (STEP)
    ) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (cmd_en),
        .addr (cmd_addr)
    );

endmodule

// File: rtl/bw_chk.sv
module bw_chk #(
    parameter int BURST  = 64,
    parameter int BL_W   = 6,
    parameter int ADDR_W = 30,
    parameter int STEP   = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              calib_ok,
    input logic              src_empty,
    input logic              src_rd_en,
    input logic              wfifo_en,
    input logic              wfifo_full,
    input logic              cmd_en,
    input logic [2:0]        cmd_op,
    input logic [BL_W-1:0]   cmd_len,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_full
);
    logic cal_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cal_seen <= 1'b0;
        else if (calib_ok)
            cal_seen <= 1'b1;
    end

    // R1
    quiet_before_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_seen |-> (!src_rd_en && !wfifo_en && !cmd_en));

    // R2
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |-> (!src_empty && !wfifo_full));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wfifo_en |-> !wfifo_full);

    // R5
    cmd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> !cmd_full);

    // R5
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |=> !cmd_en);

    // R6
    cmd_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> (cmd_op == 3'b010 && cmd_len == BL_W'(BURST - 1)));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |=> (cmd_addr == ADDR_W'($past(cmd_addr) + ADDR_W'(STEP))));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en |=> $stable(cmd_addr));

endmodule

bind dram_burst_feeder bw_chk #(
    .BURST (BURST),
    .BL_W  (BL_W),
    .ADDR_W(ADDR_W),
    .STEP  (STEP)
) u_bw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .calib_ok  (calib_ok),
    .src_empty (src_empty),
    .src_rd_en (src_rd_en),
    .wfifo_en  (wfifo_en),
    .wfifo_full(wfifo_full),
    .cmd_en    (cmd_en),
    .cmd_op    (cmd_op),
    .cmd_len   (cmd_len),
    .cmd_addr  (cmd_addr),
    .cmd_full  (cmd_full)
);

// File: tb/test_dram_burst_feeder.sv
`timescale 1ns/1ps
module test_dram_burst_feeder;
    localparam int DW     = 128;
    localparam int MW     = DW / 8;
    localparam int BURST  = 64;
    localparam int BLW    = 6;
    localparam int AW     = 12;
    localparam int NBURST = 5;
    localparam int TOTAL  = BURST * NBURST;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          calib_ok = 1'b0;
    logic          src_empty;
    logic          src_rd_en;
    logic [DW-1:0] src_data = '0;
    logic          wfifo_en;
    logic [DW-1:0] wfifo_data;
    logic [MW-1:0] wfifo_mask;
    logic          wfifo_full = 1'b0;
    logic          cmd_en;
    logic [2:0]    cmd_op;
    logic [BLW-1:0] cmd_len;
    logic [AW-1:0] cmd_addr;
    logic          cmd_full = 1'b0;

    always #5 clk = ~clk;

    dram_burst_feeder #(.DATA_W(DW), .BURST(BURST), .BL_W(BLW), .ADDR_W(AW)) i_dram_burst_feeder (
        .clk(clk), .rst_n(rst_n), .calib_ok(calib_ok),
        .src_empty(src_empty), .src_rd_en(src_rd_en), .src_data(src_data),
        .wfifo_en(wfifo_en), .wfifo_data(wfifo_data), .wfifo_mask(wfifo_mask),
        .wfifo_full(wfifo_full),
        .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_addr(cmd_addr),
        .cmd_full(cmd_full)
    );

    // local FIFO model: data registered on a pop
    logic [DW-1:0] lmem [0:511];
    int   wr_ptr = 0;
    int   rd_ptr = 0;
    logic gate_empty = 1'b0;
    assign src_empty = (wr_ptr == rd_ptr) || gate_empty;

    always @(posedge clk) begin
        if (src_rd_en && wr_ptr != rd_ptr) begin
            src_data <= lmem[rd_ptr % 512];
            rd_ptr   <= rd_ptr + 1;
        end
    end

    function automatic logic [DW-1:0] word_of(int n);
        logic [31:0] k = n;
        return {k ^ 32'hC3A5_0000, ~k, k * 32'd7 + 32'd3, k ^ 32'h5A5A_5A5A};
    endfunction

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // running reference state
    bit mon_on = 1'b0;
    bit cal_seen = 1'b0;
    bit timing_on = 1'b1;
    int pops = 0, writes = 0, pib = 0, wib = 0, pend = 0, ncmd = 0;
    int cyc = 0, last_wr_cyc = 0;
    logic [AW-1:0] exp_addr = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && mon_on) begin
            bit e_rd, e_wr, e_cmd;
            e_rd  = cal_seen && !src_empty && !wfifo_full && (pib < BURST);
            e_wr  = (pend > 0) && !wfifo_full;
            e_cmd = (wib == BURST) && !cmd_full;
            chk(src_rd_en == e_rd, cal_seen ? "R2 pop" : "R1 pop",
                $sformatf("%0b", src_rd_en), $sformatf("%0b", e_rd));
            chk(wfifo_en == e_wr, cal_seen ? "R3 write" : "R1 write",
                $sformatf("%0b", wfifo_en), $sformatf("%0b", e_wr));
            chk(cmd_en == e_cmd, (wib == BURST) ? "R5 cmd" : "R4 cmd",
                $sformatf("%0b", cmd_en), $sformatf("%0b", e_cmd));
            if (wfifo_en)
                chk(wfifo_data == word_of(writes), "R3 data order",
                    $sformatf("%h", wfifo_data), $sformatf("%h", word_of(writes)));
            if (cmd_en) begin
                chk(cmd_op == 3'b010, "R6 opcode", $sformatf("%b", cmd_op), "010");
                chk(cmd_len == 6'd63, "R6 len", $sformatf("%0d", cmd_len), "63");
                chk(cmd_addr == exp_addr, "R7 addr",
                    $sformatf("%0h", cmd_addr), $sformatf("%0h", exp_addr));
                if (timing_on)
                    chk(cyc == last_wr_cyc + 1, "R8 cmd gap",
                        $sformatf("%0d", cyc - last_wr_cyc), "1");
            end
            chk(wfifo_mask == '0, "R6 mask", $sformatf("%h", wfifo_mask), "0");
            if (src_rd_en) begin pops++; pib++; pend++; end
            if (wfifo_en) begin writes++; wib++; pend--; last_wr_cyc = cyc; end
            if (cmd_en) begin
                wib = 0; pib = 0; ncmd++;
                exp_addr = exp_addr + AW'(1024);
            end
            if (calib_ok) cal_seen = 1'b1;
        end
    end

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            lmem[wr_ptr % 512] = word_of(wr_ptr);
            wr_ptr = wr_ptr + 1;
        end
    endtask

    task automatic check_reset_outputs(input string tag);
        @(negedge clk);
        chk(src_rd_en == 1'b0, tag, $sformatf("rd_en=%0b", src_rd_en), "0");
        chk(wfifo_en == 1'b0, tag, $sformatf("wfifo_en=%0b", wfifo_en), "0");
        chk(cmd_en == 1'b0, tag, $sformatf("cmd_en=%0b", cmd_en), "0");
        chk(cmd_addr == '0, tag, $sformatf("addr=%0h", cmd_addr), "0");
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (4) @(posedge clk);
        check_reset_outputs("R9 reset state");
        @(posedge clk); #1;
        rst_n = 1'b1;
        push(TOTAL);
        mon_on = 1'b1;
        // R1: data waiting but calibration still low
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(pops == 0 && writes == 0 && ncmd == 0, "R1 idle before calibration",
            $sformatf("pops=%0d writes=%0d cmds=%0d", pops, writes, ncmd), "0/0/0");
        @(posedge clk); #1;
        calib_ok = 1'b1;
        // first burst runs unthrottled: R8 gap check is active
        while (ncmd < 1) @(posedge clk);
        #1;
        timing_on = 1'b0;
        // random throttling on all three flags
        while (ncmd < NBURST) begin
            gate_empty = ($urandom % 4) == 0;
            wfifo_full = ($urandom % 4) == 0;
            cmd_full   = ($urandom % 10) < 3;
            @(posedge clk); #1;
        end
        gate_empty = 1'b0; wfifo_full = 1'b0; cmd_full = 1'b0;
        // R5: hold a command off with a full command FIFO
        push(BURST);
        cmd_full = 1'b1;
        repeat (BURST + 20) @(posedge clk);
        @(negedge clk);
        chk(wib == BURST && ncmd == NBURST, "R5 held while cmd_full",
            $sformatf("wib=%0d cmds=%0d", wib, ncmd), $sformatf("%0d/%0d", BURST, NBURST));
        @(posedge clk); #1;
        cmd_full = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(ncmd == NBURST + 1, "R5 released", $sformatf("%0d", ncmd), $sformatf("%0d", NBURST + 1));
        chk(pops == TOTAL + BURST && writes == TOTAL + BURST, "R2 word totals",
            $sformatf("pops=%0d writes=%0d", pops, writes), $sformatf("%0d", TOTAL + BURST));
        // six bursts of 1024 bytes wrap a 4096-byte space to 2048
        chk(cmd_addr == AW'(2048), "R7 wrap", $sformatf("%0h", cmd_addr), "800");
        // mid-burst reset
        mon_on = 1'b0;
        push(10);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk);
        check_reset_outputs("R9 reset mid burst");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cmds=%0d expected %0d", ncmd, NBURST + 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule